// File: doc/BRIEF.md
# Stereo Audio FIFO and Status Controller

This block is the register and buffering front end of a full-duplex stereo audio port. It holds four separate FIFOs: a transmit queue and a receive queue for the right channel, and another pair for the left. A bus master loads outgoing samples by writing a channel's data address and drains incoming samples by reading that same address. The serial engine, which is not part of this block, is represented by per-channel pop strobes on the transmit side and push strobes with data on the receive side, one pulse per sample period.

A control register enables the port, selects an internal or external bit clock, and holds one unmask bit for each status source. A status register reports transmit and receive service requests, sticky underrun and overrun errors, and transmit-has-room and receive-has-data flags. A single registered interrupt line is raised while any unmasked status bit is set. While the port is disabled, every FIFO is held empty and all serial strobes and data accesses are ignored.

Top module: `aud_fifo_ctrl`

## Requirements
- R1: After synchronous reset, `irq`, `run_en`, `bclk_ext` and `bus_rdata` are 0, and reads of the control (address 0) and status (address 4) registers return 0.
- R2: Control register at address 0: bit 0 enable, bit 1 external bit clock, bits 7:2 unmask for status bits 5:0. It reads back its 8 bits with upper bits 0, and `run_en`/`bclk_ext` follow bits 0/1 from the cycle after the write.
- R3: A bus write to address 1 (right) or 2 (left) pushes into that channel's transmit FIFO only; the serial side sees that channel's words in write order on `ser_tx_data_*`, and an empty transmit FIFO presents 0.
- R4: A bus read of address 1 or 2 returns that channel's oldest receive word on `bus_rdata` one cycle later and removes it; reading an empty receive FIFO returns 0.
- R5: Each FIFO holds 8 words. A bus write to a full transmit FIFO is dropped; a serial push to a full receive FIFO is dropped and sets the overrun bit (status bit 3).
- R6: A serial pop from an empty transmit FIFO sets the underrun bit (status bit 2). Underrun and overrun stay set until cleared.
- R7: Writing the status address clears each sticky error bit whose write-data bit is 1 and leaves the others unchanged; other status bits are not affected by writes.
- R8: Status bit 0 (transmit service) is 1 when either transmit FIFO holds 4 or fewer words; status bit 1 (receive service) is 1 when either receive FIFO holds 4 or more words.
- R9: Status bit 4 is 1 when both transmit FIFOs have room; status bit 5 is 1 when either receive FIFO holds data.
- R10: `irq` is 1 exactly one cycle after any status bit is set whose unmask bit is 1, and 0 one cycle after none is.
- R11: While bit 0 of control is 0, all FIFOs are emptied, bus data writes, data-address reads and serial strobes have no effect, and status bits 0, 1, 4, 5 read 0.
- R12: Address 3 always reads 0 and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address (0 control, 1 right data, 2 left data, 3 spare, 4 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| ser_tx_pop | input | 2 | Serial-side transmit pop strobes (bit 0 right, bit 1 left) |
| ser_tx_data_r | output | 16 | Right transmit FIFO head word |
| ser_tx_data_l | output | 16 | Left transmit FIFO head word |
| ser_rx_push | input | 2 | Serial-side receive push strobes (bit 0 right, bit 1 left) |
| ser_rx_data_r | input | 16 | Right receive sample |
| ser_rx_data_l | input | 16 | Left receive sample |
| run_en | output | 1 | Port enabled |
| bclk_ext | output | 1 | External bit clock selected |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted FIFO pointer or count shows at the ports within one access: a serial pop presents a word out of write order, a bus read returns the wrong sample, or the status flags disagree with the number of words pushed, since every fill level from empty to over-full is swept on both sides. A sticky bit that drops or fails to set is seen on the next status read and, once unmasked, on `irq` one cycle later. State left behind after disabling appears as a non-zero status or data read immediately after re-enabling.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int NCH    = 2;
  localparam int ST_TXREQ = 0;
  localparam int ST_RXREQ = 1;
  localparam int ST_UNDR  = 2;
  localparam int ST_OVR   = 3;
  localparam int ST_TXNF  = 4;
  localparam int ST_RXNE  = 5;
  localparam int ST_W     = 6;
  localparam int CTRL_W   = 2 + ST_W;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_DATA_R = 3'd1,
    A_DATA_L = 3'd2,
    A_SPARE  = 3'd3,
    A_STAT   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [$clog2(DEPTH):0] cnt,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic push_ok, pop_ok;

  assign full    = (cnt == CAP);
  assign empty   = (cnt == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CAP);
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (cnt == $past(cnt)));
  assert_flush_empty_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/aud_status.sv
module aud_status
  import aud_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [NCH-1:0]  tx_low,
  input  logic [NCH-1:0]  rx_high,
  input  logic [NCH-1:0]  tx_full,
  input  logic [NCH-1:0]  rx_empty,
  input  logic            undr_evt,
  input  logic            ovr_evt,
  input  logic            clr_wr,
  input  logic [ST_W-1:0] clr_bits,
  input  logic [ST_W-1:0] unmask,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic undr_q, ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      undr_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      undr_q <= (undr_q && !(clr_wr && clr_bits[ST_UNDR])) || undr_evt;
      ovr_q  <= (ovr_q  && !(clr_wr && clr_bits[ST_OVR]))  || ovr_evt;
      irq    <= |(status & unmask);
    end
  end

  always_comb begin
    status           = '0;
    status[ST_TXREQ] = en && (|tx_low);
    status[ST_RXREQ] = en && (|rx_high);
    status[ST_UNDR]  = undr_q;
    status[ST_OVR]   = ovr_q;
    status[ST_TXNF]  = en && !(|tx_full);
    status[ST_RXNE]  = en && !(&rx_empty);
  end

  assert_undr_sets_R6: assert property (@(posedge clk) disable iff (rst)
    undr_evt |=> status[ST_UNDR]);
  assert_ovr_sets_R5: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> status[ST_OVR]);
  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (status[ST_OVR] && !(clr_wr && clr_bits[ST_OVR])) |=> status[ST_OVR]);
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ((status & unmask) == '0) |=> !irq);
endmodule

// File: rtl/aud_fifo_ctrl.sv
module aud_fifo_ctrl
  import aud_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [2:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] ser_tx_pop,
  output logic [DW-1:0]  ser_tx_data_r,
  output logic [DW-1:0]  ser_tx_data_l,
  input  logic [NCH-1:0] ser_rx_push,
  input  logic [DW-1:0]  ser_rx_data_r,
  input  logic [DW-1:0]  ser_rx_data_l,
  output logic           run_en,
  output logic           bclk_ext,
  output logic           irq
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [CTRL_W-1:0] ctrl_q;
  logic [ST_W-1:0]   status;
  logic              en, flush;
  logic [NCH-1:0]    sel;
  logic [NCH-1:0]    tx_push, tx_pop, tx_full, tx_empty, tx_low;
  logic [NCH-1:0]    rx_push, rx_pop, rx_full, rx_empty, rx_high;
  logic [DW-1:0]     tx_head [NCH];
  logic [DW-1:0]     rx_head [NCH];
  logic [DW-1:0]     rx_in   [NCH];
  logic [DW-1:0]     tx_out  [NCH];
  logic              unused_wdata;

  assign en       = ctrl_q[0];
  assign flush    = !en;
  assign run_en   = ctrl_q[0];
  assign bclk_ext = ctrl_q[1];
  assign unused_wdata = ^bus_wdata[DW-1:CTRL_W];

  assign sel[0]   = (bus_addr == A_DATA_R);
  assign sel[1]   = (bus_addr == A_DATA_L);
  assign rx_in[0] = ser_rx_data_r;
  assign rx_in[1] = ser_rx_data_l;
  assign ser_tx_data_r = tx_out[0];
  assign ser_tx_data_l = tx_out[1];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CW-1:0] tx_cnt, rx_cnt;

    assign tx_push[ch] = en && bus_wr && sel[ch];
    assign tx_pop[ch]  = en && ser_tx_pop[ch];
    assign rx_push[ch] = en && ser_rx_push[ch];
    assign rx_pop[ch]  = en && bus_rd && sel[ch];
    assign tx_low[ch]  = (tx_cnt <= HALF);
    assign rx_high[ch] = (rx_cnt >= HALF);
    assign tx_out[ch]  = tx_empty[ch] ? '0 : tx_head[ch];

    aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx (
      .clk(clk), .rst(rst), .flush(flush),
      .push(tx_push[ch]), .pop(tx_pop[ch]), .wdata(bus_wdata),
      .head(tx_head[ch]), .cnt(tx_cnt), .full(tx_full[ch]), .empty(tx_empty[ch])
    );

    aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx (
      .clk(clk), .rst(rst), .flush(flush),
      .push(rx_push[ch]), .pop(rx_pop[ch]), .wdata(rx_in[ch]),
      .head(rx_head[ch]), .cnt(rx_cnt), .full(rx_full[ch]), .empty(rx_empty[ch])
    );
  end

  aud_status u_stat (
    .clk(clk), .rst(rst), .en(en),
    .tx_low(tx_low), .rx_high(rx_high), .tx_full(tx_full), .rx_empty(rx_empty),
    .undr_evt(|(tx_pop & tx_empty)),
    .ovr_evt(|(rx_push & rx_full)),
    .clr_wr(bus_wr && bus_addr == A_STAT),
    .clr_bits(bus_wdata[ST_W-1:0]),
    .unmask(ctrl_q[CTRL_W-1:2]),
    .status(status),
    .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:   bus_rdata <= DW'(ctrl_q);
        A_DATA_R: bus_rdata <= (rx_empty[0] || !en) ? '0 : rx_head[0];
        A_DATA_L: bus_rdata <= (rx_empty[1] || !en) ? '0 : rx_head[1];
        A_STAT:   bus_rdata <= DW'(status);
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assert_spare_zero_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_SPARE) |=> (bus_rdata == '0));
  assert_off_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (!run_en && bus_rd && bus_addr == A_DATA_L) |=> (bus_rdata == '0));
  assert_tx_empty_zero_R3: assert property (@(posedge clk) disable iff (rst)
    tx_empty[0] |-> (ser_tx_data_r == '0));
endmodule

// File: tb/aud_fifo_ctrl_test.sv
module aud_fifo_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  ser_tx_pop = '0, ser_rx_push = '0;
  logic [15:0] ser_tx_data_r, ser_tx_data_l;
  logic [15:0] ser_rx_data_r = '0, ser_rx_data_l = '0;
  logic        run_en, bclk_ext, irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aud_fifo_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_tx_pop(ser_tx_pop),
    .ser_tx_data_r(ser_tx_data_r), .ser_tx_data_l(ser_tx_data_l),
    .ser_rx_push(ser_rx_push), .ser_rx_data_r(ser_rx_data_r),
    .ser_rx_data_l(ser_rx_data_l), .run_en(run_en), .bclk_ext(bclk_ext), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic spush(input int ch, input logic [15:0] d);
    @(negedge clk);
    ser_rx_push[ch] = 1'b1;
    if (ch == 0) ser_rx_data_r = d; else ser_rx_data_l = d;
    @(negedge clk); ser_rx_push = '0;
  endtask

  task automatic spop(input int ch, output logic [15:0] d);
    @(negedge clk);
    ser_tx_pop[ch] = 1'b1;
    d = (ch == 0) ? ser_tx_data_r : ser_tx_data_l;
    @(negedge clk); ser_tx_pop = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq", irq, 0);
    chk("R1 run_en", run_en, 0);
    chk("R1 bclk_ext", bclk_ext, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);

    wr(3'd0, 16'hFFFF);
    rd(3'd0, v); chk("R2 ctrl readback", v, 16'h00FF);
    chk("R2 run_en", run_en, 1);
    chk("R2 bclk_ext", bclk_ext, 1);
    wr(3'd0, 16'h0001);
    rd(3'd0, v); chk("R2 ctrl readback", v, 16'h0001);
    chk("R2 bclk_ext off", bclk_ext, 0);
    rd(3'd4, v); chk("R8 R9 idle status", v, 16'h0011);

    for (int i = 0; i < 9; i++) wr(3'd1, 16'h0100 + 16'(i));
    rd(3'd4, v); chk("R8 left empty", v, 16'h0001);
    for (int k = 0; k < 10; k++) begin
      wr(3'd2, 16'h0200 + 16'(k));
      c = (k + 1 > 8) ? 8 : k + 1;
      rd(3'd4, v); chk("R8 R9 tx fill", v, (c <= 4) ? 32'h1 : 32'h0);
    end
    for (int i = 0; i < 9; i++) begin
      spop(1, v);
      chk("R3 R5 left order", v, (i < 8) ? 32'(16'h0200 + 16'(i)) : 32'h0);
    end
    rd(3'd4, v); chk("R6 underrun", v, 16'h0005);
    for (int i = 0; i < 8; i++) begin
      spop(0, v); chk("R3 R5 right order", v, 32'(16'h0100 + 16'(i)));
    end
    @(negedge clk); chk("R5 ninth dropped", ser_tx_data_r, 0);
    rd(3'd4, v); chk("R9 tx room", v, 16'h0015);
    wr(3'd4, 16'h0000); rd(3'd4, v); chk("R7 no clear", v, 16'h0015);
    wr(3'd4, 16'h0008); rd(3'd4, v); chk("R7 other bit", v, 16'h0015);
    wr(3'd4, 16'h0004); rd(3'd4, v); chk("R7 clear undr", v, 16'h0011);

    for (int k = 1; k <= 9; k++) begin
      spush(1, 16'h0300 + 16'(k - 1));
      c = (k > 8) ? 8 : k;
      rd(3'd4, v);
      chk("R5 R8 R9 rx fill", v, 32'h31 | ((c >= 4) ? 32'h2 : 32'h0) | ((k == 9) ? 32'h8 : 32'h0));
    end
    for (int i = 0; i < 9; i++) begin
      rd(3'd2, v); chk("R4 left read", v, (i < 8) ? 32'(16'h0300 + 16'(i)) : 32'h0);
    end
    rd(3'd1, v); chk("R4 right empty", v, 0);
    spush(0, 16'h00A0); spush(0, 16'h00A1); spush(1, 16'h00B0);
    rd(3'd1, v); chk("R4 right first", v, 16'h00A0);
    rd(3'd2, v); chk("R4 left only", v, 16'h00B0);
    rd(3'd1, v); chk("R4 right second", v, 16'h00A1);
    wr(3'd4, 16'h0008); rd(3'd4, v); chk("R7 clear ovr", v, 16'h0011);

    wr(3'd3, 16'h1234);
    rd(3'd3, v); chk("R12 spare zero", v, 0);
    rd(3'd4, v); chk("R12 status kept", v, 16'h0011);
    rd(3'd0, v); chk("R12 ctrl kept", v, 16'h0001);

    chk("R10 masked", irq, 0);
    wr(3'd0, 16'h0021); @(negedge clk);
    chk("R10 ovr clear", irq, 0);
    for (int i = 0; i < 9; i++) spush(1, 16'h0400 + 16'(i));
    @(negedge clk); chk("R10 ovr irq", irq, 1);
    wr(3'd4, 16'h0008); @(negedge clk);
    chk("R10 irq drops", irq, 0);
    wr(3'd0, 16'h0005); @(negedge clk);
    chk("R10 txreq irq", irq, 1);

    wr(3'd1, 16'h0055); wr(3'd1, 16'h0056);
    wr(3'd0, 16'h0000); @(negedge clk);
    chk("R11 run_en", run_en, 0);
    chk("R11 irq", irq, 0);
    rd(3'd4, v); chk("R11 off status", v, 0);
    wr(3'd1, 16'h0077);
    spush(0, 16'h0088);
    spop(1, v);
    rd(3'd2, v); chk("R11 off read", v, 0);
    wr(3'd0, 16'h0001);
    rd(3'd4, v); chk("R11 flushed status", v, 16'h0011);
    rd(3'd2, v); chk("R11 rx flushed", v, 0);
    @(negedge clk); chk("R11 tx flushed", ser_tx_data_r, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule